// File: doc/BRIEF.md
# Light-Load Burst and Supply Holdup Gate Controller

This block sits between the oscillator and the gate driver of a current-mode flyback controller. Once per switching period it decides whether that period carries an ordinary PWM pulse, a forced minimum-energy pulse, or no pulse at all. It acts on five digitized comparator flags: three from the feedback node and two from the controller's own supply rail. When the load is light, the feedback falls and the block blanks switching. It keeps the blanking until the feedback has climbed back to a higher level, so there is hysteresis between entry and exit.

A second hysteresis loop watches the supply. Suppose the feedback sits below the holdup arming level and the supply sags to the holdup entry level. The block then overrides both the PWM loop and burst blanking and requests sparse forced pulses. This keeps the rail from reaching its undervoltage turn-off point. A gap counter rate-limits forced pulses. In burst, it also guarantees a minimum effective switching frequency. A protection shutdown input overrides everything.

Each flag passes through a two-stage synchronizer. Mode decisions are taken only on the clock edge that carries `cycle_start`. Both outputs are registered and held for the whole period, so no pulse is ever cut short by a mid-period change.

Top module: `burst_hold_ctrl`

## Requirements
- R1: After a synchronous reset, `pwm_en` and `force_pulse` are low, both the burst and holdup modes are inactive, and the gap count restarts at 1.
- R2: Every comparator flag is delayed by a two-stage synchronizer. A flag changed 2 clock edges before a `cycle_start` edge is not yet seen by that decision, and a flag changed 3 or more edges before is seen.
- R3: When neither burst nor holdup is active at a `cycle_start` edge, the period is a normal one: `pwm_en`=1 and `force_pulse`=0.
- R4: Burst is entered when the synchronized `fb_below_lo` is 1 at a `cycle_start` edge. Normal pulses are then blanked (`pwm_en`=0).
- R5: Burst is left only when the synchronized `fb_above_hi` is 1 at a `cycle_start` edge. With both burst feedback flags low, the burst state is kept.
- R6: The gap count is the number of clock edges since the last cycle start that issued a pulse, or since reset or shutdown. It saturates at the larger limit. In burst without holdup, a cycle start whose gap count is at least BURST_GAP issues `force_pulse`=1. A lower count issues nothing.
- R7: Holdup is entered at a `cycle_start` edge when `fb_below_hold` and `sup_below_entry` are both 1. It is left when `sup_above_exit` is 1 or `fb_below_hold` is 0. Otherwise it is kept.
- R8: Holdup has priority over normal and burst operation. While in holdup, `pwm_en`=0 and `force_pulse`=1 only when the gap count is at least HOLD_GAP. The burst limit does not apply.
- R9: Without `shutdown`, `pwm_en` and `force_pulse` change only on `cycle_start` edges. Flag changes in mid-period leave them unchanged.
- R10: `shutdown` high drives both outputs low on the next edge, even without a cycle start, and restarts the gap count. Normal decisions resume at the first cycle start after release.
- R11: `pwm_en` and `force_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_start | input | 1 | One-clock marker of the start of an oscillator period |
| fb_below_lo | input | 1 | Feedback below the low burst level |
| fb_above_hi | input | 1 | Feedback above the high burst level |
| fb_below_hold | input | 1 | Feedback below the holdup arming level |
| sup_below_entry | input | 1 | Supply below the holdup entry level |
| sup_above_exit | input | 1 | Supply above the holdup exit level |
| shutdown | input | 1 | Protection shutdown, forces both outputs low |
| pwm_en | output | 1 | Normal PWM pulse permitted for this period |
| force_pulse | output | 1 | Forced minimum-energy pulse requested for this period |

## Verification
The bench steps the gap count to exactly one edge below and exactly at each limit. A counter that is off by one, or that compares against the wrong limit in holdup, would fire a forced pulse early or skip it. The bench also parks the feedback between the two burst levels and the supply between the two holdup levels. A design without hysteresis would leave its mode there. Flags are changed two edges and then three edges before a cycle start to pin the synchronizer latency. Flags are also changed mid-period to catch a design that truncates or starts pulses off the period boundary. Shutdown is raised without a cycle start to confirm that it acts at once.

// File: rtl/burst_hold_pkg.sv
package burst_hold_pkg;
  localparam int FLAG_N    = 5;
  localparam int F_FB_LO   = 0;
  localparam int F_FB_HI   = 1;
  localparam int F_FB_HOLD = 2;
  localparam int F_SUP_LO  = 3;
  localparam int F_SUP_HI  = 4;

  typedef enum logic [1:0] {
    SEL_IDLE  = 2'b00,
    SEL_PWM   = 2'b01,
    SEL_FORCE = 2'b10
  } pulse_sel_e;
endpackage

// File: rtl/bh_sync_bank.sv
module bh_sync_bank #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/bh_hyst_latch.sv
module bh_hyst_latch (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic set_c,
  input  logic clr_c,
  output logic q,
  output logic q_next
);
  always_comb begin
    q_next = q;
    if (sample) begin
      if (!q && set_c)     q_next = 1'b1;
      else if (q && clr_c) q_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end
endmodule

// File: rtl/bh_gap_counter.sv
module bh_gap_counter #(
  parameter int LIMIT = 12500,
  parameter int W     = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] SAT = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= W'(1);
    else if (cnt != SAT) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/bh_pulse_select.sv
module bh_pulse_select
  import burst_hold_pkg::*;
#(
  parameter int BURST_GAP = 5682,
  parameter int HOLD_GAP  = 12500,
  parameter int W         = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cycle_start,
  input  logic         shutdown,
  input  logic         burst_next,
  input  logic         hold_next,
  input  logic [W-1:0] gap,
  output logic         pwm_en,
  output logic         force_pulse,
  output logic         issue
);
  localparam logic [W-1:0] LIM_B = W'(BURST_GAP);
  localparam logic [W-1:0] LIM_H = W'(HOLD_GAP);

  pulse_sel_e sel;

  always_comb begin
    if (hold_next)       sel = (gap >= LIM_H) ? SEL_FORCE : SEL_IDLE;
    else if (burst_next) sel = (gap >= LIM_B) ? SEL_FORCE : SEL_IDLE;
    else                 sel = SEL_PWM;
  end

  assign issue = cycle_start && !shutdown && (sel != SEL_IDLE);

  always_ff @(posedge clk) begin
    if (rst || shutdown) begin
      pwm_en      <= 1'b0;
      force_pulse <= 1'b0;
    end else if (cycle_start) begin
      pwm_en      <= (sel == SEL_PWM);
      force_pulse <= (sel == SEL_FORCE);
    end
  end
endmodule

// File: rtl/burst_hold_ctrl.sv
module burst_hold_ctrl
  import burst_hold_pkg::*;
#(
  parameter int BURST_GAP   = 5682,
  parameter int HOLD_GAP    = 12500,
  parameter int SYNC_STAGES = 2,
  localparam int GAP_MAX    = (BURST_GAP > HOLD_GAP) ? BURST_GAP : HOLD_GAP,
  localparam int CNT_W      = $clog2(GAP_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cycle_start,
  input  logic fb_below_lo,
  input  logic fb_above_hi,
  input  logic fb_below_hold,
  input  logic sup_below_entry,
  input  logic sup_above_exit,
  input  logic shutdown,
  output logic pwm_en,
  output logic force_pulse
);
  logic [FLAG_N-1:0] raw_flags, s_flags;
  logic              burst_q, burst_nx, hold_q, hold_nx;
  logic              issue;
  logic [CNT_W-1:0]  gap_q;

  always_comb begin
    raw_flags            = '0;
    raw_flags[F_FB_LO]   = fb_below_lo;
    raw_flags[F_FB_HI]   = fb_above_hi;
    raw_flags[F_FB_HOLD] = fb_below_hold;
    raw_flags[F_SUP_LO]  = sup_below_entry;
    raw_flags[F_SUP_HI]  = sup_above_exit;
  end

  bh_sync_bank #(.WIDTH(FLAG_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_flags), .q(s_flags)
  );

  bh_hyst_latch u_burst (
    .clk(clk), .rst(rst), .sample(cycle_start),
    .set_c(s_flags[F_FB_LO]), .clr_c(s_flags[F_FB_HI]),
    .q(burst_q), .q_next(burst_nx)
  );

  bh_hyst_latch u_hold (
    .clk(clk), .rst(rst), .sample(cycle_start),
    .set_c(s_flags[F_FB_HOLD] && s_flags[F_SUP_LO]),
    .clr_c(s_flags[F_SUP_HI] || !s_flags[F_FB_HOLD]),
    .q(hold_q), .q_next(hold_nx)
  );

  bh_gap_counter #(.LIMIT(GAP_MAX), .W(CNT_W)) u_gap (
    .clk(clk), .rst(rst), .restart(issue || shutdown), .cnt(gap_q)
  );

  bh_pulse_select #(.BURST_GAP(BURST_GAP), .HOLD_GAP(HOLD_GAP), .W(CNT_W)) u_sel (
    .clk(clk), .rst(rst), .cycle_start(cycle_start), .shutdown(shutdown),
    .burst_next(burst_nx), .hold_next(hold_nx), .gap(gap_q),
    .pwm_en(pwm_en), .force_pulse(force_pulse), .issue(issue)
  );
endmodule

// File: rtl/burst_hold_chk.sv
module burst_hold_chk #(
  parameter int BURST_GAP = 5682,
  parameter int HOLD_GAP  = 12500,
  parameter int CNT_W     = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             cycle_start,
  input logic             shutdown,
  input logic             pwm_en,
  input logic             force_pulse,
  input logic [CNT_W-1:0] gap_q
);
  localparam int MIN_GAP = (BURST_GAP < HOLD_GAP) ? BURST_GAP : HOLD_GAP;

  AST_SHUTDOWN_LOW: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (!pwm_en && !force_pulse)); // R10
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pwm_en && force_pulse)); // R11
  AST_MID_CYCLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!cycle_start && !shutdown) |=> ($stable(pwm_en) && $stable(force_pulse))); // R9
  AST_NO_EARLY_FORCE: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && !shutdown && (int'(gap_q) < MIN_GAP)) |=> !force_pulse); // R6
  AST_PWM_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_en) |-> $past(cycle_start)); // R3
endmodule

bind burst_hold_ctrl burst_hold_chk #(
  .BURST_GAP(BURST_GAP), .HOLD_GAP(HOLD_GAP), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cycle_start(cycle_start), .shutdown(shutdown),
  .pwm_en(pwm_en), .force_pulse(force_pulse), .gap_q(gap_q)
);

// File: tb/burst_hold_ctrl_bench.sv
module burst_hold_ctrl_bench;
  localparam int BG = 20;
  localparam int HG = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cycle_start = 1'b0;
  logic fb_lo = 1'b0, fb_hi = 1'b0, fb_hold = 1'b0;
  logic sup_lo = 1'b0, sup_hi = 1'b0, shutdown = 1'b0;
  logic pwm_en, force_pulse;
  int   total = 0;
  int   bad   = 0;

  always #4 clk = ~clk;

  burst_hold_ctrl #(.BURST_GAP(BG), .HOLD_GAP(HG)) u_burst_hold_ctrl (
    .clk(clk), .rst(rst), .cycle_start(cycle_start),
    .fb_below_lo(fb_lo), .fb_above_hi(fb_hi), .fb_below_hold(fb_hold),
    .sup_below_entry(sup_lo), .sup_above_exit(sup_hi), .shutdown(shutdown),
    .pwm_en(pwm_en), .force_pulse(force_pulse)
  );

  task automatic check(string req, logic [1:0] exp);
    total++;
    if ({pwm_en, force_pulse} !== exp) begin
      bad++;
      $display("FAIL %s: {pwm_en,force_pulse} actual=%b expected=%b", req, {pwm_en, force_pulse}, exp);
    end
  endtask

  task automatic set_flags(logic lo, logic hi, logic hold, logic slo, logic shi);
    fb_lo = lo; fb_hi = hi; fb_hold = hold; sup_lo = slo; sup_hi = shi;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; shutdown = 1'b0; cycle_start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // cycle_start lands n clock edges after the previous one
  task automatic do_cycle(int n);
    for (int i = 1; i < n; i++) @(negedge clk);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
  endtask

  task automatic t_reset();
    set_flags(0, 0, 0, 0, 1);
    do_reset();
    check("R1 reset idle", 2'b00);
    do_cycle(5);
    check("R3 normal after reset", 2'b10);
  endtask

  task automatic t_sync_latency();
    set_flags(1, 0, 0, 0, 1);
    do_cycle(2);
    check("R2 flag 2 edges old not seen", 2'b10);
    do_cycle(1);
    check("R2 flag 3 edges old seen", 2'b00);
  endtask

  task automatic t_burst();
    do_reset();
    set_flags(0, 1, 0, 0, 1);
    do_cycle(5);
    check("R3 normal", 2'b10);
    set_flags(1, 0, 0, 0, 1);
    do_cycle(5);
    check("R4 burst entry blanks", 2'b00);
    set_flags(0, 0, 0, 0, 1);
    do_cycle(5);
    check("R5 burst kept between levels", 2'b00);
    do_cycle(9);
    check("R6 gap 19 no force", 2'b00);
    do_cycle(1);
    check("R6 gap 20 forces", 2'b01);
    do_cycle(5);
    check("R6 gap restarted after force", 2'b00);
    set_flags(0, 1, 0, 0, 1);
    do_cycle(5);
    check("R5 burst exit", 2'b10);
  endtask

  task automatic t_mid_cycle();
    set_flags(1, 0, 0, 0, 1);
    repeat (6) @(negedge clk);
    check("R9 no change mid-period", 2'b10);
    do_cycle(1);
    check("R4 change at next start", 2'b00);
  endtask

  task automatic t_holdup();
    do_reset();
    set_flags(1, 0, 1, 1, 0);
    do_cycle(5);
    check("R8 holdup gap 5 idle", 2'b00);
    do_cycle(30);
    check("R8 holdup ignores burst limit", 2'b00);
    do_cycle(15);
    check("R8 holdup gap 50 forces", 2'b01);
    set_flags(1, 0, 1, 0, 0);
    do_cycle(50);
    check("R7 holdup kept between supply levels", 2'b01);
    set_flags(1, 0, 1, 0, 1);
    do_cycle(5);
    check("R7 holdup exit to burst", 2'b00);
    do_cycle(20);
    check("R6 burst limit back after holdup", 2'b01);
  endtask

  task automatic t_hold_arming();
    do_reset();
    set_flags(0, 0, 0, 1, 0);
    do_cycle(60);
    check("R7 no holdup while feedback high", 2'b10);
    set_flags(0, 0, 1, 1, 0);
    do_cycle(5);
    check("R8 holdup overrides normal", 2'b00);
    set_flags(0, 0, 0, 1, 0);
    do_cycle(5);
    check("R7 holdup exit on feedback rise", 2'b10);
  endtask

  task automatic t_shutdown();
    check("R10 precondition normal", 2'b10);
    shutdown = 1'b1;
    @(negedge clk);
    check("R10 immediate low", 2'b00);
    do_cycle(4);
    check("R10 cycle start ignored", 2'b00);
    shutdown = 1'b0;
    @(negedge clk);
    check("R10 low until cycle start", 2'b00);
    do_cycle(3);
    check("R10 resume", 2'b10);
    set_flags(1, 0, 0, 0, 1);
    do_cycle(5);
    shutdown = 1'b1;
    @(negedge clk);
    shutdown = 1'b0;
    do_cycle(19);
    check("R10 gap restarted by shutdown", 2'b00);
    do_cycle(1);
    check("R11 force alone", 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sync_latency();
    t_burst();
    t_mid_cycle();
    t_holdup();
    t_hold_arming();
    t_shutdown();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule